// File: doc/BRIEF.md
# Iterative RC5 Block Cipher Engine

This block encrypts or decrypts one 64-bit block with RC5 using 32-bit words and 12 rounds. It uses a single register for the cipher state, one round of combinational logic that is reused on every cycle, and a multiplexer in front of the register. The multiplexer picks either a freshly loaded block or the output of the round logic. The round keys are computed elsewhere and held in an external round-key store. The engine reads that store by round number, two words at a time, through a read port with no clock delay.

A start pulse, sampled while the engine is idle, captures the input block and the direction select. The engine then walks the rounds upward for encryption or downward for decryption. The key-whitening step takes place while the block is loaded when encrypting, and in an extra cycle after the last round when decrypting. A one-cycle done pulse marks a valid result. The result stays on the output until the next accepted start.

Top module: `rc5_iter_core`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `done` is 0, `roundAddr` is 0 and `blockOut` is 0.
- R2: With `decryptSel` = 0, the result is RC5 encryption. Word A is `blockIn[31:0]` and word B is `blockIn[63:32]`. First A += S[0] and B += S[1]. Then for i = 1..12: A = rotl(A^B, B[4:0]) + S[2i], followed by B = rotl(B^A, A[4:0]) + S[2i+1]. The result is placed as {B, A}. All additions are modulo 2^32.
- R3: With `decryptSel` = 1, the result is RC5 decryption. For i = 12 down to 1: B = rotr(B − S[2i+1], A[4:0]) ^ A, followed by A = rotr(A − S[2i], B[4:0]) ^ B. Then B −= S[1] and A −= S[0]. Decrypting an encrypted block returns the original block.
- R4: For encryption, `done` is high in the 13th cycle after the cycle in which `start` was sampled. `roundAddr` reads 1, 2, ..., 12 in cycles 1 to 12 and reads 0 from cycle 13 on.
- R5: For decryption, `done` is high in the 14th cycle after the start cycle. `roundAddr` reads 12, 11, ..., 1 in cycles 1 to 12 and reads 0 from cycle 13 on.
- R6: `done` is high for exactly one cycle. `blockOut` holds the result until the next accepted start, whatever `blockIn` and `decryptSel` do in the meantime.
- R7: A `start` pulse that arrives while an operation is running is ignored. The result and the timing of that operation are unchanged. A start in the same cycle as `done` is accepted.
- R8: The round-key store is read with no clock delay. At address `roundAddr` = i, `keyA` must carry S[2i] and `keyB` must carry S[2i+1]. While idle the address is 0, which supplies S[0] and S[1] for whitening at load. `roundAddr` never exceeds 12.
- R9: The direction is captured at start. Changes on `decryptSel` during an operation have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| decryptSel | input | 1 | 0 = encrypt, 1 = decrypt; sampled with start |
| blockIn | input | 64 | Input block {B, A} |
| keyA | input | 32 | Round-key word S[2i] for the current address |
| keyB | input | 32 | Round-key word S[2i+1] for the current address |
| roundAddr | output | 4 | Round number addressing the round-key store |
| blockOut | output | 64 | Result block {B, A} |
| done | output | 1 | One-cycle pulse, result valid |

## Verification
The bench builds the engine with its default parameters: 32-bit words and 12 rounds. With these values the round keys can be produced by the standard key expansion of an all-zero 16-byte key, so a published known-answer vector for encryption and decryption can be checked directly. A second, arbitrary key table drives round trips over several data patterns. A behavioural reference model follows the address sequence, the done pulse and the held result on every clock. That makes the 13- and 14-cycle latencies, the ignored mid-run starts and the back-to-back restarts visible cycle by cycle.

// File: rtl/rc5_iter_pkg.sv
package rc5_iter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FINAL = 2'd2
  } rc5State_t;

  // strobes from the control to the datapath; at most one is high
  typedef struct packed {
    logic loadEnc;   // load block with whitening added
    logic loadDec;   // load block unchanged
    logic encRound;  // apply one forward round
    logic decRound;  // apply one inverse round
    logic unwhiten;  // subtract the round-0 key pair
  } rc5Strobe_t;

endpackage

// File: rtl/rc5_round_fn.sv
module rc5_round_fn #(
  parameter int WORD_W  = 32,
  parameter bit INVERSE = 1'b0
) (
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] bIn,
  input  logic [WORD_W-1:0] keyA,
  input  logic [WORD_W-1:0] keyB,
  output logic [WORD_W-1:0] aOut,
  output logic [WORD_W-1:0] bOut
);
  localparam int SH_W = $clog2(WORD_W);

  function automatic logic [WORD_W-1:0] rotLeft(input logic [WORD_W-1:0] x,
                                                input logic [SH_W-1:0] s);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << s;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  function automatic logic [WORD_W-1:0] rotRight(input logic [WORD_W-1:0] x,
                                                 input logic [SH_W-1:0] s);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} >> s;
    return dbl[WORD_W-1:0];
  endfunction

  generate
    if (INVERSE) begin : g_inverse
      logic [WORD_W-1:0] bMid;
      always_comb begin
        bMid = rotRight(bIn - keyB, aIn[SH_W-1:0]) ^ aIn;
        aOut = rotRight(aIn - keyA, bMid[SH_W-1:0]) ^ bMid;
        bOut = bMid;
      end
    end else begin : g_forward
      logic [WORD_W-1:0] aMid;
      always_comb begin
        aMid = rotLeft(aIn ^ bIn, bIn[SH_W-1:0]) + keyA;
        bOut = rotLeft(bIn ^ aMid, aMid[SH_W-1:0]) + keyB;
        aOut = aMid;
      end
    end
  endgenerate

endmodule

// File: rtl/rc5_iter_ctrl.sv
module rc5_iter_ctrl
  import rc5_iter_pkg::*;
#(
  parameter int ROUNDS = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              decryptSel,
  output rc5Strobe_t        strobe,
  output logic [ADDR_W-1:0] roundAddr,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_RND  = ADDR_W'(ROUNDS);
  localparam logic [ADDR_W-1:0] FIRST_RND = ADDR_W'(1);

  rc5State_t         stateQ;
  logic              dirDecQ;
  logic [ADDR_W-1:0] cntQ;
  logic              doneQ;

  always_comb begin
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          if (decryptSel) strobe.loadDec = 1'b1;
          else            strobe.loadEnc = 1'b1;
        end
      end
      ST_RUN: begin
        if (dirDecQ) strobe.decRound = 1'b1;
        else         strobe.encRound = 1'b1;
      end
      ST_FINAL: strobe.unwhiten = 1'b1;
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_IDLE;
      dirDecQ <= 1'b0;
      cntQ    <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (start) begin
            dirDecQ <= decryptSel;
            cntQ    <= decryptSel ? LAST_RND : FIRST_RND;
            stateQ  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!dirDecQ) begin
            if (cntQ == LAST_RND) begin
              cntQ   <= '0;
              doneQ  <= 1'b1;
              stateQ <= ST_IDLE;
            end else begin
              cntQ <= cntQ + FIRST_RND;
            end
          end else begin
            if (cntQ == FIRST_RND) begin
              cntQ   <= '0;
              stateQ <= ST_FINAL;
            end else begin
              cntQ <= cntQ - FIRST_RND;
            end
          end
        end
        ST_FINAL: begin
          doneQ  <= 1'b1;
          stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign roundAddr = cntQ;
  assign done      = doneQ;

  // R8: the key address stays inside the round-key store
  a_r8_addr_range: assert property (@(posedge clk) disable iff (rst)
    cntQ <= LAST_RND);

  // R4: forward rounds walk the address upward by one
  a_r4_enc_step: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_RUN && !dirDecQ && cntQ != LAST_RND)
      |=> (cntQ == $past(cntQ) + FIRST_RND));

  // R5: inverse rounds walk the address downward by one
  a_r5_dec_step: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_RUN && dirDecQ && cntQ != FIRST_RND)
      |=> (cntQ == $past(cntQ) - FIRST_RND));

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

  // R9: direction is frozen while an operation runs
  a_r9_dir_hold: assert property (@(posedge clk) disable iff (rst)
    (stateQ != ST_IDLE) |=> (stateQ == ST_IDLE || $stable(dirDecQ)));

  // R7: a start during a run never yields a load
  a_r7_busy_no_load: assert property (@(posedge clk) disable iff (rst)
    (stateQ != ST_IDLE && start) |-> !(strobe.loadEnc || strobe.loadDec));

endmodule

// File: rtl/rc5_iter_datapath.sv
module rc5_iter_datapath
  import rc5_iter_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  rc5Strobe_t          strobe,
  input  logic [2*WORD_W-1:0] blockIn,
  input  logic [WORD_W-1:0]   keyA,
  input  logic [WORD_W-1:0]   keyB,
  output logic [2*WORD_W-1:0] blockOut
);
  localparam int BLK_W = 2 * WORD_W;

  logic [BLK_W-1:0]  stateQ;
  logic [BLK_W-1:0]  stateNext;
  logic [WORD_W-1:0] curA, curB, inA, inB;
  logic [WORD_W-1:0] encA, encB, decA, decB;

  assign curA = stateQ[WORD_W-1:0];
  assign curB = stateQ[BLK_W-1:WORD_W];
  assign inA  = blockIn[WORD_W-1:0];
  assign inB  = blockIn[BLK_W-1:WORD_W];

  rc5_round_fn #(.WORD_W(WORD_W), .INVERSE(1'b0)) fwdRound (
    .aIn(curA), .bIn(curB), .keyA(keyA), .keyB(keyB),
    .aOut(encA), .bOut(encB)
  );

  rc5_round_fn #(.WORD_W(WORD_W), .INVERSE(1'b1)) invRound (
    .aIn(curA), .bIn(curB), .keyA(keyA), .keyB(keyB),
    .aOut(decA), .bOut(decB)
  );

  always_comb begin
    stateNext = stateQ;
    if (strobe.loadEnc)       stateNext = {inB + keyB, inA + keyA};
    else if (strobe.loadDec)  stateNext = blockIn;
    else if (strobe.encRound) stateNext = {encB, encA};
    else if (strobe.decRound) stateNext = {decB, decA};
    else if (strobe.unwhiten) stateNext = {curB - keyB, curA - keyA};
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= '0;
    else     stateQ <= stateNext;
  end

  assign blockOut = stateQ;

  // R6: with no strobe the held result does not move
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (strobe == '0) |=> $stable(stateQ));

  // R7: the control never asks for two actions at once
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

endmodule

// File: rtl/rc5_iter_core.sv
module rc5_iter_core
  import rc5_iter_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 12,
  localparam int ADDR_W = $clog2(ROUNDS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                decryptSel,
  input  logic [2*WORD_W-1:0] blockIn,
  input  logic [WORD_W-1:0]   keyA,
  input  logic [WORD_W-1:0]   keyB,
  output logic [ADDR_W-1:0]   roundAddr,
  output logic [2*WORD_W-1:0] blockOut,
  output logic                done
);
  rc5Strobe_t strobe;

  rc5_iter_ctrl #(.ROUNDS(ROUNDS), .ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rst(rst), .start(start), .decryptSel(decryptSel),
    .strobe(strobe), .roundAddr(roundAddr), .done(done)
  );

  rc5_iter_datapath #(.WORD_W(WORD_W)) dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .blockIn(blockIn),
    .keyA(keyA), .keyB(keyB), .blockOut(blockOut)
  );

  // R1: outputs are quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!done && roundAddr == '0 && blockOut == '0));

endmodule

// File: tb/rc5_iter_core_test.sv
`timescale 1ns/1ps
module rc5_iter_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        decryptSel = 1'b0;
  logic [63:0] blockIn = '0;
  logic [31:0] keyA, keyB;
  logic [3:0]  roundAddr;
  logic [63:0] blockOut;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] S [0:25];

  always #10 clk = ~clk;

  assign keyA = (roundAddr <= 4'd12) ? S[2*roundAddr]     : 32'hx;
  assign keyB = (roundAddr <= 4'd12) ? S[2*roundAddr + 1] : 32'hx;

  rc5_iter_core uut (
    .clk(clk), .rst(rst), .start(start), .decryptSel(decryptSel),
    .blockIn(blockIn), .keyA(keyA), .keyB(keyB),
    .roundAddr(roundAddr), .blockOut(blockOut), .done(done)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int s);
    return (x << s) | (x >> (32 - s));
  endfunction

  function automatic logic [31:0] rr(input logic [31:0] x, input int s);
    return (x >> s) | (x << (32 - s));
  endfunction

  function automatic logic [63:0] encModel(input logic [63:0] blk);
    logic [31:0] a, b;
    a = blk[31:0] + S[0];
    b = blk[63:32] + S[1];
    for (int i = 1; i <= 12; i++) begin
      a = rl(a ^ b, b % 32) + S[2*i];
      b = rl(b ^ a, a % 32) + S[2*i+1];
    end
    return {b, a};
  endfunction

  function automatic logic [63:0] decModel(input logic [63:0] blk);
    logic [31:0] a, b;
    a = blk[31:0];
    b = blk[63:32];
    for (int i = 12; i >= 1; i--) begin
      b = rr(b - S[2*i+1], a % 32) ^ a;
      a = rr(a - S[2*i], b % 32) ^ b;
    end
    return {b - S[1], a - S[0]};
  endfunction

  task automatic loadZeroKey();
    logic [31:0] L [0:3];
    logic [31:0] x, y;
    int i, j;
    for (int k = 0; k < 4; k++) L[k] = '0;
    S[0] = 32'hB7E15163;
    for (int k = 1; k < 26; k++) S[k] = S[k-1] + 32'h9E3779B9;
    x = '0; y = '0; i = 0; j = 0;
    for (int k = 0; k < 78; k++) begin
      S[i] = rl(S[i] + x + y, 3);
      x = S[i];
      L[j] = rl(L[j] + x + y, (x + y) % 32);
      y = L[j];
      i = (i + 1) % 26;
      j = (j + 1) % 4;
    end
  endtask

  task automatic loadOtherKey();
    logic [31:0] v = 32'h1234_5678;
    for (int k = 0; k < 26; k++) begin
      v = v * 32'd1664525 + 32'd1013904223;
      S[k] = v ^ {v[15:0], v[31:16]};
    end
  endtask

  // behavioural cycle model
  int          mState = 0;
  bit          mDec = 0;
  int          mLeft = 0;
  int          mAddr = 0;
  bit          mDone = 0;
  bit          mValid = 1;
  logic [63:0] mOut = '0;
  logic [63:0] mRes = '0;

  always @(posedge clk) begin
    if (rst) begin
      mState = 0; mAddr = 0; mDone = 0; mValid = 1; mOut = '0;
    end else begin
      mDone = 0;
      if (mState == 0) begin
        if (start) begin
          mDec   = decryptSel;
          mRes   = decryptSel ? decModel(blockIn) : encModel(blockIn);
          mValid = 0;
          mLeft  = decryptSel ? 13 : 12;
          mAddr  = decryptSel ? 12 : 1;
          mState = 1;
        end
      end else begin
        mLeft--;
        if (mDec) mAddr = (mAddr > 0) ? mAddr - 1 : 0;
        else      mAddr = (mAddr == 12) ? 0 : mAddr + 1;
        if (mLeft == 0) begin
          mState = 0; mDone = 1; mOut = mRes; mValid = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(done == mDone, "R6 model done", 64'(done), 64'(mDone));
      check(roundAddr == 4'(mAddr), "R4 R5 R8 model address",
            64'(roundAddr), 64'(mAddr));
      if (mValid) check(blockOut == mOut, "R6 model held result", blockOut, mOut);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic runOp(input logic dec, input logic [63:0] blk,
                       output logic [63:0] res, output int cyc,
                       input int midAt, input logic [63:0] midBlk,
                       input logic flipDir);
    start = 1'b1; decryptSel = dec; blockIn = blk;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    // R8: first address after the start edge
    check(roundAddr == (dec ? 4'd12 : 4'd1), "R8 first address",
          64'(roundAddr), dec ? 64'd12 : 64'd1);
    while (!done && cyc < 40) begin
      if (cyc == midAt) begin
        start = 1'b1;
        blockIn = midBlk;
        if (flipDir) decryptSel = ~dec;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    res = blockOut;
    if (dec) check(cyc == 14, "R5 latency", 64'(cyc), 64'd14);
    else     check(cyc == 13, "R4 latency", 64'(cyc), 64'd13);
  endtask

  initial begin
    logic [63:0] ct, pt, res, v;
    int cyc;
    loadZeroKey();
    repeat (3) @(negedge clk);
    check(done == 1'b0 && roundAddr == 4'd0 && blockOut == '0, "R1 during reset",
          {roundAddr, 59'd0, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && roundAddr == 4'd0 && blockOut == '0, "R1 after reset",
          blockOut, 64'd0);

    // R2 known answer with all-zero key
    runOp(1'b0, 64'd0, ct, cyc, 0, '0, 1'b0);
    check(ct == 64'h6D8F4B15_EEDBA521, "R2 known answer", ct, 64'h6D8F4B15_EEDBA521);
    // R3 back to plaintext, started in the done cycle (R7)
    runOp(1'b1, ct, pt, cyc, 0, '0, 1'b0);
    check(pt == 64'd0, "R3 known answer inverse", pt, 64'd0);

    // R6 pulse width and hold under changing inputs
    blockIn = 64'hDEAD_BEEF_0BAD_F00D; decryptSel = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    check(blockOut == 64'd0, "R6 result held", blockOut, 64'd0);

    loadOtherKey();
    v = 64'h0123_4567_89AB_CDEF;
    for (int n = 0; n < 6; n++) begin
      v = {v[62:0], v[63] ^ v[60] ^ v[1]} * 64'd6364136223846793005 + 64'(n);
      runOp(1'b0, v, ct, cyc, 0, '0, 1'b0);
      check(ct == encModel(v), "R2 encrypt pattern", ct, encModel(v));
      runOp(1'b1, ct, pt, cyc, 0, '0, 1'b0);
      check(pt == v, "R3 round trip", pt, v);
      @(negedge clk);
    end

    // R7 start mid-run ignored
    v = 64'hFFFF_FFFF_0000_0001;
    runOp(1'b0, v, ct, cyc, 4, 64'h5555_AAAA_3333_CCCC, 1'b0);
    check(ct == encModel(v), "R7 mid-run start ignored", ct, encModel(v));
    // R9 direction flip mid-run ignored
    runOp(1'b1, ct, pt, cyc, 6, 64'h1111_2222_3333_4444, 1'b1);
    check(pt == v, "R9 direction change ignored", pt, v);
    runOp(1'b0, 64'h8000_0000_7FFF_FFFF, ct, cyc, 11, '0, 1'b1);
    check(ct == encModel(64'h8000_0000_7FFF_FFFF), "R9 flip late in run",
          ct, encModel(64'h8000_0000_7FFF_FFFF));
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule